// File: doc/BRIEF.md
# Sticky Reset-Cause Flag Register

This block is an 8-bit status register. It records which on-chip monitor caused the recent resets. Three monitors can each raise a one-cycle request: a watchdog, a clock monitor and a supply-voltage detector. Each request sets a flag assigned to that monitor. Any flag already set stays set, so one read after restart shows every internal cause since the last clear.

The register sits in the power-on domain, so internal resets do not clear it. Only three things bring a flag back to zero:
- the power-on reset;
- a reset from the external reset pin, which clears the whole register;
- a software clear.

Software clears flags by writing zeros. It can write the whole byte, or it can address a single bit by its index. A write-enable input stands in for the unlock sequence, and software writes count only while it is high.

When a hardware set and any clear hit the same flag in the same cycle, the set wins. This covers both a software clear and a pin clear.

Top module: `rst_cause_reg`

## Requirements
- R1: While the synchronous active-high `rst` is high, `rdata` becomes 0x00 at the next clock edge.
- R2: A cycle with `pin_rst` high clears every flag, so `rdata` reads 0x00 after that edge unless R9 applies.
- R3: A high `src_req[2]` (watchdog) sets bit 4. A high `src_req[1]` (clock monitor) sets bit 1. A high `src_req[0]` (voltage detector) sets bit 0. Every other flag keeps its value.
- R4: Bits 7, 6, 5, 3 and 2 of `rdata` always read 0.
- R5: With `wr_unlock` and `byte_we` high, each flag whose bit in `byte_wdata` is 0 is cleared. A 1 in `byte_wdata` leaves its flag unchanged.
- R6: With `wr_unlock` and `bit_we` high, the flag at position `bit_idx` is cleared when `bit_val` is 0. When `bit_val` is 1, nothing changes. An index that names a reserved bit changes nothing.
- R7: While `wr_unlock` is low, byte writes and bit writes have no effect on `rdata`.
- R8: A source request and a software clear of the same flag in the same cycle leave that flag set.
- R9: A source request in the same cycle as `pin_rst` leaves that source's flag set and clears the others.
- R10: In a cycle with no request, no pin reset and no enabled write, `rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Power-on domain clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| pin_rst | input | 1 | External pin reset indication; clears all flags |
| src_req | input | 3 | Reset requests: [2] watchdog, [1] clock monitor, [0] voltage detector |
| wr_unlock | input | 1 | Enables software writes |
| byte_we | input | 1 | Whole-byte write strobe |
| byte_wdata | input | 8 | Byte write data; 0 bits clear flags |
| bit_we | input | 1 | Single-bit write strobe |
| bit_idx | input | 3 | Bit position for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write; 0 clears |
| rdata | output | 8 | Registered flag contents |

## Verification
Two kinds of event can land on the same flag in one clock:
- a hardware set and a software clear;
- a hardware set and a pin clear.

The bench produces the first case by raising a source request in the cycle of a byte write of 0x00. It repeats this with a single-bit clear of the same position. It produces the second case by pairing a clock-monitor request with `pin_rst`. In each case it reads `rdata` one edge later. The requested flag must read 1. In the pin case, every other flag must read 0.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

  localparam int FLAG_W    = 8;
  localparam int NUM_SRC   = 3;
  localparam int POS_VOLT  = 0;
  localparam int POS_CLKM  = 1;
  localparam int POS_WDOG  = 4;

  // bit position owned by request line k
  function automatic int src_pos(input int k);
    case (k)
      0:       return POS_VOLT;
      1:       return POS_CLKM;
      default: return POS_WDOG;
    endcase
  endfunction

  // positions that hold a real flag
  function automatic logic [31:0] impl_mask(input int nsrc);
    logic [31:0] m;
    m = '0;
    for (int k = 0; k < nsrc; k++) m[src_pos(k)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/rsf_clr_dec.sv
module rsf_clr_dec #(
  parameter int W   = 8,
  parameter int IW  = 3
) (
  input  logic          wr_unlock,
  input  logic          byte_we,
  input  logic [W-1:0]  byte_wdata,
  input  logic          bit_we,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  output logic [W-1:0]  clr_mask
);

  always_comb begin
    clr_mask = '0;
    if (wr_unlock) begin
      if (byte_we) clr_mask = ~byte_wdata;
      for (int i = 0; i < W; i++) begin
        if (bit_we && !bit_val && (bit_idx == IW'(i))) clr_mask[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rsf_flag_cell.sv
module rsf_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  // R1: power-on reset empties the flag
  p_por_clear_r1: assert property (@(posedge clk) rst |=> !q);
  // R8: set wins over a coincident clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q);
  // R2: a clear with no set empties the flag
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q);
  // R10: idle flag holds
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !set_i) |=> $stable(q));

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rsf_pkg::*;
#(
  parameter int REG_W  = FLAG_W,
  parameter int NSRC   = NUM_SRC,
  parameter int IDX_W  = $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_rst,
  input  logic [NSRC-1:0]  src_req,
  input  logic             wr_unlock,
  input  logic             byte_we,
  input  logic [REG_W-1:0] byte_wdata,
  input  logic             bit_we,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_val,
  output logic [REG_W-1:0] rdata
);

  localparam logic [31:0]      IMPL32 = impl_mask(NSRC);
  localparam logic [REG_W-1:0] IMPL   = IMPL32[REG_W-1:0];

  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] sw_clr;

  always_comb begin
    set_vec = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (src_req[k]) set_vec[src_pos(k)] = 1'b1;
    end
  end

  rsf_clr_dec #(.W(REG_W), .IW(IDX_W)) u_dec (
    .wr_unlock  (wr_unlock),
    .byte_we    (byte_we),
    .byte_wdata (byte_wdata),
    .bit_we     (bit_we),
    .bit_idx    (bit_idx),
    .bit_val    (bit_val),
    .clr_mask   (sw_clr)
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_flag
      rsf_flag_cell u_cell (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_vec[i]),
        .clr_i (pin_rst | sw_clr[i]),
        .q     (rdata[i])
      );
    end else begin : g_rsvd
      assign rdata[i] = 1'b0;
    end
  end

  // R4: reserved positions never read 1
  p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~IMPL) == '0);
  // R7: locked writes leave the register alone
  p_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (!wr_unlock && !pin_rst && src_req == '0) |=> $stable(rdata));
  // R3: a watchdog request sets its flag
  p_wdog_set_r3: assert property (@(posedge clk) disable iff (rst)
    src_req[NSRC-1] |=> rdata[POS_WDOG]);

endmodule

// File: tb/test_rst_cause_reg.sv
module test_rst_cause_reg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_rst = 1'b0;
  logic [2:0] src_req = '0;
  logic       wr_unlock = 1'b0;
  logic       byte_we = 1'b0;
  logic [7:0] byte_wdata = '0;
  logic       bit_we = 1'b0;
  logic [2:0] bit_idx = '0;
  logic       bit_val = 1'b0;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_reg i_rst_cause_reg (
    .clk(clk), .rst(rst), .pin_rst(pin_rst), .src_req(src_req),
    .wr_unlock(wr_unlock), .byte_we(byte_we), .byte_wdata(byte_wdata),
    .bit_we(bit_we), .bit_idx(bit_idx), .bit_val(bit_val), .rdata(rdata)
  );

  task automatic chk(input string req, input logic [7:0] exp);
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata=0x%02h expected=0x%02h", req, rdata, exp);
    end
  endtask

  // one clock edge; inputs changed at negedge, sampled at the next negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    pin_rst = 0; src_req = '0; byte_we = 0; bit_we = 0;
  endtask

  task automatic set_all();
    src_req = 3'b111; step();
  endtask

  task automatic t_reset();
    rst = 1; step(); step();
    chk("R1", 8'h00);
    rst = 0; step();
  endtask

  task automatic t_sources();
    src_req = 3'b100; step(); chk("R3 wdog", 8'h10);
    src_req = 3'b010; step(); chk("R3 clkm", 8'h12);
    src_req = 3'b001; step(); chk("R3 volt", 8'h13);
    n_chk++;
    if ((rdata & 8'hEC) !== 8'h00) begin
      n_bad++;
      $display("FAIL R4: rdata=0x%02h expected reserved=0", rdata);
    end
    repeat (5) step();
    chk("R10 hold", 8'h13);
    pin_rst = 1; step(); chk("R2 pin", 8'h00);
  endtask

  task automatic t_byte_clear();
    set_all(); chk("R3 all", 8'h13);
    wr_unlock = 1;
    byte_we = 1; byte_wdata = 8'hFD; step(); chk("R5 clear b1", 8'h11);
    byte_we = 1; byte_wdata = 8'hFF; step(); chk("R5 ones", 8'h11);
    byte_we = 1; byte_wdata = 8'h00; step(); chk("R5 zero", 8'h00);
    wr_unlock = 0;
  endtask

  task automatic t_bit_clear();
    set_all();
    wr_unlock = 1;
    bit_we = 1; bit_idx = 3'd4; bit_val = 0; step(); chk("R6 clr b4", 8'h03);
    bit_we = 1; bit_idx = 3'd0; bit_val = 1; step(); chk("R6 val1", 8'h03);
    bit_we = 1; bit_idx = 3'd3; bit_val = 0; step(); chk("R6 rsvd", 8'h03);
    bit_we = 1; bit_idx = 3'd0; bit_val = 0; step(); chk("R6 clr b0", 8'h02);
    wr_unlock = 0;
  endtask

  task automatic t_locked();
    set_all();
    wr_unlock = 0;
    byte_we = 1; byte_wdata = 8'h00; step(); chk("R7 byte", 8'h13);
    bit_we = 1; bit_idx = 3'd1; bit_val = 0; step(); chk("R7 bit", 8'h13);
  endtask

  task automatic t_set_vs_clear();
    wr_unlock = 1;
    byte_we = 1; byte_wdata = 8'h00; src_req = 3'b100; step();
    chk("R8 byte", 8'h10);
    set_all();
    bit_we = 1; bit_idx = 3'd0; bit_val = 0; src_req = 3'b001; step();
    chk("R8 bit", 8'h13);
    wr_unlock = 0;
  endtask

  task automatic t_set_vs_pin();
    set_all();
    pin_rst = 1; src_req = 3'b010; step();
    chk("R9", 8'h02);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sources();
    t_byte_clear();
    t_bit_clear();
    t_locked();
    t_set_vs_clear();
    t_set_vs_pin();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule